// File: doc/BRIEF.md
# Cached Page-Table Address Translator

This block sits between a requester and memory and turns 32-bit virtual addresses into physical addresses. Each 4 KiB virtual page has one entry in a single-level table held in main memory, and a base register inside the block points at that table. A small fully associative cache of recent translations is searched on every request. A hit completes in the cycle the request is presented. A miss stalls the requester while the block reads one table entry from memory through a simple read request/response port. The block then checks that entry against the requested operation, returns the result and, if the entry is usable, installs it in the cache.

A write to the base register switches the block to a different table. It clears every cached translation in the same cycle. If the write lands while an entry read is outstanding, the block throws away the returned entry and repeats the lookup against the new table. An entry that is invalid, or that forbids the requested operation, produces a fault indication instead of an address.

Top module: `pt_xlate`

## Requirements
- R1: After reset the cache is empty, no entry read is requested, `req_ready` is low while no request is present, and the first translation of any page performs an entry read.
- R2: A request whose page number matches a cached entry completes with `req_ready` high in the same cycle it is presented, and no entry read takes place.
- R3: On a miss `req_ready` stays low and exactly one entry read is issued at address base + 4 × page number. `pte_rd` and `pte_rd_addr` hold steady until `pte_rsp_valid`, and the result is presented in the cycle after the response.
- R4: The entry word is bit 22 = valid, bits 21:20 = access code, bits 19:0 = frame. A granted access returns `{frame, offset}` and a fault returns an address of zero.
- R5: Operation codes on `req_op` are 00 read, 01 write, 10 execute, 11 reserved. Access codes are 00 read-only, 01 read/write, 10 execute-only, 11 read/write/execute. A fault is raised for an invalid entry, for an operation the code does not allow, and always for operation 11.
- R6: An entry that faults is not installed, so a repeated request to that page reads memory again.
- R7: The low 12 offset bits of the virtual address pass unchanged into the physical address.
- R8: A write to the base register invalidates every cached entry. Later requests to previously cached pages read the entry from the new table.
- R9: If the base register is written while an entry read is outstanding, that response is discarded and a new read is issued at the new base for the same page. The result comes from the new table.
- R10: A refill uses the lowest-numbered free slot if one exists. Otherwise it uses the slot under a round-robin pointer, which starts at 0, advances by one only when it picks a victim, and is not reset by a base write.
- R11: In a cycle in which the base register is written, no translation completes (`req_ready` is low), even for a page that was cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present; held with its address and operation until `req_ready` |
| req_vaddr | input | 32 | Virtual address |
| req_op | input | 2 | Requested operation |
| req_ready | output | 1 | Translation completes this cycle |
| xl_paddr | output | 32 | Physical address, valid with `req_ready` |
| xl_fault | output | 1 | Page-fault indication, valid with `req_ready` |
| tbl_base_we | input | 1 | Write strobe for the table base register |
| tbl_base_wdata | input | 32 | New table base address |
| pte_rd | output | 1 | Entry read request, held until response |
| pte_rd_addr | output | 32 | Byte address of the requested entry |
| pte_rsp_valid | input | 1 | Entry read response |
| pte_rsp_data | input | 23 | Returned table entry |

## Verification
Random requests over a pool of twelve page numbers, with random offsets and all four operation codes, give a mix of hits, misses, faulting entries and evictions. Comparing each against a reference cache tells the same-cycle hit path apart from the stalled fetch path. Pages whose entry forbids reads are requested twice in a row, which separates a correct non-install from a cache that keeps faulting entries. Nine usable pages are filled after a flush and the first eight are then revisited, which exposes the free-slot-first and round-robin victim choice. Base writes are placed in three positions: between requests, in the same cycle as a request to a cached page, and while an entry read is held open. Together they distinguish the flush, the completion stall and the discard-and-refetch behaviour.

// File: rtl/pt_xlate_pkg.sv
`timescale 1ns/1ps
package pt_xlate_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE    = 2'd0,
    WALK_FETCH   = 2'd1,
    WALK_RESPOND = 2'd2
  } walk_state_e;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_EXEC  = 2'd2;

  localparam logic [1:0] ACC_RO  = 2'd0;
  localparam logic [1:0] ACC_RW  = 2'd1;
  localparam logic [1:0] ACC_XO  = 2'd2;
  localparam logic [1:0] ACC_RWX = 2'd3;

endpackage

// File: rtl/pt_perm_check.sv
`timescale 1ns/1ps
module pt_perm_check
  import pt_xlate_pkg::*;
(
  input  logic       ent_valid,
  input  logic [1:0] ent_acc,
  input  logic [1:0] op,
  output logic       grant
);

  logic op_ok;

  always_comb begin
    op_ok = 1'b0;
    case (op)
      OP_READ:  op_ok = (ent_acc == ACC_RO) || (ent_acc == ACC_RW) || (ent_acc == ACC_RWX);
      OP_WRITE: op_ok = (ent_acc == ACC_RW) || (ent_acc == ACC_RWX);
      OP_EXEC:  op_ok = (ent_acc == ACC_XO) || (ent_acc == ACC_RWX);
      default:  op_ok = 1'b0;
    endcase
    grant = ent_valid && op_ok;
  end

endmodule

// File: rtl/pt_tlb_array.sv
`timescale 1ns/1ps
module pt_tlb_array #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int DATA_W  = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [DATA_W-1:0]  lk_data,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [DATA_W-1:0]  fill_data,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] hit_vec
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [IDX_W-1:0]   rr_q, rr_d;
  logic [IDX_W-1:0]   free_idx, victim;
  logic               have_free;

  // parallel tag compare, one comparator per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_vpn);
  end

  assign lk_hit    = |hit_vec;
  assign valid_vec = valid_q;

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_data = lk_data | (data_q[i] & {DATA_W{hit_vec[i]}});
    end
  end

  // lowest free slot first, else the round-robin slot
  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
    victim = have_free ? free_idx : rr_q;
  end

  always_comb begin
    valid_d = valid_q;
    rr_d    = rr_q;
    if (flush) begin
      valid_d = '0;
    end else if (fill_en) begin
      valid_d[victim] = 1'b1;
      if (!have_free) begin
        rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
    end
  end

  // slot payload: clock-enabled, no reset
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic slot_we;
    assign slot_we = fill_en && !flush && (victim == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        tag_q[g]  <= fill_vpn;
        data_q[g] <= fill_data;
      end
    end
  end

endmodule

// File: rtl/pt_walk_fsm.sv
`timescale 1ns/1ps
module pt_walk_fsm
  import pt_xlate_pkg::*;
#(
  parameter int PA_W      = 32,
  parameter int VPN_W     = 20,
  parameter int PTE_W     = 23,
  parameter int ENT_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic              lk_hit,
  input  logic              base_we,
  input  logic [PA_W-1:0]   base_q,
  input  logic              rsp_valid,
  input  logic [PTE_W-1:0]  rsp_data,
  output walk_state_e       state,
  output logic              rd_req,
  output logic [PA_W-1:0]   rd_addr,
  output logic [VPN_W-1:0]  fetch_vpn,
  output logic [PTE_W-1:0]  pte_q
);

  walk_state_e      st_q, st_d;
  logic             discard_q, discard_d;
  logic             load_addr, load_pte;
  logic [PA_W-1:0]  addr_q, addr_d;
  logic [VPN_W-1:0] vpn_q;

  assign addr_d = base_q + PA_W'({req_vpn, {ENT_SHIFT{1'b0}}});

  always_comb begin
    st_d      = st_q;
    discard_d = discard_q;
    load_addr = 1'b0;
    load_pte  = 1'b0;
    case (st_q)
      WALK_IDLE: begin
        if (req_valid && !lk_hit && !base_we) begin
          st_d      = WALK_FETCH;
          load_addr = 1'b1;
          discard_d = 1'b0;
        end
      end
      WALK_FETCH: begin
        if (base_we) discard_d = 1'b1;
        if (rsp_valid) begin
          if (discard_q || base_we) begin
            st_d      = WALK_IDLE;
            discard_d = 1'b0;
          end else begin
            st_d     = WALK_RESPOND;
            load_pte = 1'b1;
          end
        end
      end
      WALK_RESPOND: st_d = WALK_IDLE;
      default:      st_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= WALK_IDLE;
      discard_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      discard_q <= discard_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_addr) begin
      addr_q <= addr_d;
      vpn_q  <= req_vpn;
    end
    if (load_pte) begin
      pte_q <= rsp_data;
    end
  end

  assign state     = st_q;
  assign rd_req    = (st_q == WALK_FETCH);
  assign rd_addr   = addr_q;
  assign fetch_vpn = vpn_q;

endmodule

// File: rtl/pt_xlate.sv
`timescale 1ns/1ps
module pt_xlate
  import pt_xlate_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 20,
  parameter int ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [VA_W-1:0]            req_vaddr,
  input  logic [1:0]                 req_op,
  output logic                       req_ready,
  output logic [FRAME_W+OFF_W-1:0]   xl_paddr,
  output logic                       xl_fault,
  input  logic                       tbl_base_we,
  input  logic [FRAME_W+OFF_W-1:0]   tbl_base_wdata,
  output logic                       pte_rd,
  output logic [FRAME_W+OFF_W-1:0]   pte_rd_addr,
  input  logic                       pte_rsp_valid,
  input  logic [FRAME_W+2:0]         pte_rsp_data
);

  localparam int VPN_W   = VA_W - OFF_W;
  localparam int PA_W    = FRAME_W + OFF_W;
  localparam int ACC_W   = 2;
  localparam int DATA_W  = ACC_W + FRAME_W;
  localparam int PTE_W   = DATA_W + 1;
  localparam int V_BIT   = PTE_W - 1;
  localparam int ACC_LSB = FRAME_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // table base register
  logic [PA_W-1:0] base_q, base_d;

  assign base_d = tbl_base_we ? tbl_base_wdata : base_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) base_q <= '0;
    else            base_q <= base_d;
  end

  logic [VPN_W-1:0]   req_vpn;
  logic [OFF_W-1:0]   req_off;
  logic               lk_hit;
  logic [DATA_W-1:0]  lk_data;
  logic               fill_en;
  logic [ENTRIES-1:0] tlb_valid;
  logic [ENTRIES-1:0] tlb_hit;
  walk_state_e        walk_st;
  logic [VPN_W-1:0]   fetch_vpn;
  logic [PTE_W-1:0]   pte_q;

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];
  assign req_off = req_vaddr[OFF_W-1:0];

  pt_tlb_array #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .DATA_W  (DATA_W)
  ) u_tlb (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .flush     (tbl_base_we),
    .lk_vpn    (req_vpn),
    .lk_hit    (lk_hit),
    .lk_data   (lk_data),
    .fill_en   (fill_en),
    .fill_vpn  (fetch_vpn),
    .fill_data (pte_q[DATA_W-1:0]),
    .valid_vec (tlb_valid),
    .hit_vec   (tlb_hit)
  );

  pt_walk_fsm #(
    .PA_W      (PA_W),
    .VPN_W     (VPN_W),
    .PTE_W     (PTE_W),
    .ENT_SHIFT (2)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_vpn   (req_vpn),
    .lk_hit    (lk_hit),
    .base_we   (tbl_base_we),
    .base_q    (base_q),
    .rsp_valid (pte_rsp_valid),
    .rsp_data  (pte_rsp_data),
    .state     (walk_st),
    .rd_req    (pte_rd),
    .rd_addr   (pte_rd_addr),
    .fetch_vpn (fetch_vpn),
    .pte_q     (pte_q)
  );

  // result source: cache on a hit, fetched entry in the respond state
  logic               sel_valid;
  logic [ACC_W-1:0]   sel_acc;
  logic [FRAME_W-1:0] sel_frame;
  logic               grant;
  logic               in_respond;

  assign in_respond = (walk_st == WALK_RESPOND);

  always_comb begin
    if (in_respond) begin
      sel_valid = pte_q[V_BIT];
      sel_acc   = pte_q[ACC_LSB +: ACC_W];
      sel_frame = pte_q[FRAME_W-1:0];
    end else begin
      sel_valid = 1'b1;
      sel_acc   = lk_data[ACC_LSB +: ACC_W];
      sel_frame = lk_data[FRAME_W-1:0];
    end
  end

  pt_perm_check u_perm (
    .ent_valid (sel_valid),
    .ent_acc   (sel_acc),
    .op        (req_op),
    .grant     (grant)
  );

  assign req_ready = !tbl_base_we &&
                     (((walk_st == WALK_IDLE) && req_valid && lk_hit) || in_respond);
  assign xl_fault  = !grant;
  assign xl_paddr  = grant ? {sel_frame, req_off} : '0;
  assign fill_en   = in_respond && !tbl_base_we && grant;

endmodule

// File: rtl/pt_xlate_chk.sv
`timescale 1ns/1ps
module pt_xlate_chk #(
  parameter int PA_W    = 32,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic [VA_W-1:0]    req_vaddr,
  input logic [PA_W-1:0]    xl_paddr,
  input logic               xl_fault,
  input logic               tbl_base_we,
  input logic               pte_rd,
  input logic [PA_W-1:0]    pte_rd_addr,
  input logic               pte_rsp_valid,
  input logic [ENTRIES-1:0] tlb_valid,
  input logic [ENTRIES-1:0] tlb_hit,
  input logic [1:0]         walk_st
);

  assert_read_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pte_rd && !pte_rsp_valid |=> pte_rd && $stable(pte_rd_addr));

  assert_one_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pte_rd && pte_rsp_valid |=> !pte_rd);

  assert_hit_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !pte_rd);

  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tlb_hit));

  assert_offset_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && !xl_fault |-> xl_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]);

  assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && xl_fault |-> xl_paddr == '0);

  assert_flush_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_base_we |=> tlb_valid == '0);

  assert_base_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_base_we |-> !req_ready);

  assert_fault_no_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_st == 2'd2) && xl_fault && !tbl_base_we
      |=> $countones(tlb_valid) == $past($countones(tlb_valid)));

endmodule

bind pt_xlate pt_xlate_chk #(
  .PA_W    (PA_W),
  .VA_W    (VA_W),
  .OFF_W   (OFF_W),
  .ENTRIES (ENTRIES)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .xl_paddr      (xl_paddr),
  .xl_fault      (xl_fault),
  .tbl_base_we   (tbl_base_we),
  .pte_rd        (pte_rd),
  .pte_rd_addr   (pte_rd_addr),
  .pte_rsp_valid (pte_rsp_valid),
  .tlb_valid     (tlb_valid),
  .tlb_hit       (tlb_hit),
  .walk_st       (walk_st)
);

// File: tb/test_pt_xlate.sv
`timescale 1ns/1ps
module test_pt_xlate;

  localparam int ENTRIES = 8;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_op;
  logic        req_ready;
  logic [31:0] xl_paddr;
  logic        xl_fault;
  logic        tbl_base_we;
  logic [31:0] tbl_base_wdata;
  logic        pte_rd;
  logic [31:0] pte_rd_addr;
  logic        pte_rsp_valid;
  logic [22:0] pte_rsp_data;

  pt_xlate #(.ENTRIES(ENTRIES)) i_pt_xlate (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_vaddr      (req_vaddr),
    .req_op         (req_op),
    .req_ready      (req_ready),
    .xl_paddr       (xl_paddr),
    .xl_fault       (xl_fault),
    .tbl_base_we    (tbl_base_we),
    .tbl_base_wdata (tbl_base_wdata),
    .pte_rd         (pte_rd),
    .pte_rd_addr    (pte_rd_addr),
    .pte_rsp_valid  (pte_rsp_valid),
    .pte_rsp_data   (pte_rsp_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory responder state
  int          rsp_cnt = 0;
  int          rsp_cyc = 0;
  int          wait_n = 1;
  bit          hold_rsp = 0;
  logic [31:0] last_addr = '0;

  // reference cache
  logic [19:0] m_vpn [ENTRIES];
  logic [22:0] m_pte [ENTRIES];
  bit          m_v   [ENTRIES];
  int          m_rr = 0;
  logic [31:0] m_base = '0;

  function automatic logic [22:0] mem_word(logic [31:0] a);
    logic [31:0] h;
    h = a * 32'h9E3779B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    h = h ^ (h >> 13);
    return h[22:0];
  endfunction

  function automatic bit perm_ok(logic [1:0] acc, logic [1:0] op);
    case (op)
      2'd0:    return acc != 2'd2;
      2'd1:    return (acc == 2'd1) || (acc == 2'd3);
      2'd2:    return acc[1];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] ent_addr(logic [31:0] b, logic [19:0] v);
    return b + 32'({v, 2'b00});
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_flush(logic [31:0] nb);
    for (int i = 0; i < ENTRIES; i++) m_v[i] = 1'b0;
    m_base = nb;
  endtask

  task automatic model_install(logic [19:0] v, logic [22:0] e);
    int slot;
    slot = -1;
    for (int i = ENTRIES - 1; i >= 0; i--) if (!m_v[i]) slot = i;
    if (slot < 0) begin
      slot = m_rr;
      m_rr = (m_rr + 1) % ENTRIES;
    end
    m_v[slot]   = 1'b1;
    m_vpn[slot] = v;
    m_pte[slot] = e;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    pte_rsp_valid = 1'b0;
    pte_rsp_data  = '0;
    forever begin
      @(negedge clk);
      pte_rsp_valid = 1'b0;
      if (pte_rd && !hold_rsp) begin
        if (wait_n == 0) begin
          pte_rsp_valid = 1'b1;
          pte_rsp_data  = mem_word(pte_rd_addr);
          last_addr     = pte_rd_addr;
          rsp_cyc       = cyc;
          rsp_cnt++;
          wait_n = $urandom_range(0, 2);
        end else begin
          wait_n--;
        end
      end
    end
  end

  task automatic write_base(logic [31:0] nb);
    @(negedge clk);
    tbl_base_we    = 1'b1;
    tbl_base_wdata = nb;
    @(negedge clk);
    tbl_base_we = 1'b0;
    model_flush(nb);
  endtask

  task automatic run_req(input logic [31:0] va, input logic [1:0] op, input bit with_base,
                         input logic [31:0] nb, output logic flt, output logic [31:0] pa,
                         output logic first_rdy, output int rdy_cyc);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_op    = op;
    if (with_base) begin
      tbl_base_we    = 1'b1;
      tbl_base_wdata = nb;
    end
    #1;
    first_rdy = req_ready;
    if (with_base) begin
      @(negedge clk);
      tbl_base_we = 1'b0;
      #1;
    end
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    flt     = xl_fault;
    pa      = xl_paddr;
    rdy_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_xact(logic [31:0] va, logic [1:0] op, bit with_base,
                            logic [31:0] nb, string tag);
    logic [19:0] v;
    logic [22:0] e;
    logic [31:0] ea, exp_pa, pa;
    logic        exp_flt, flt, first_rdy;
    int          idx, r0, rc;
    v = va[31:12];
    if (with_base) model_flush(nb);
    idx = -1;
    for (int i = 0; i < ENTRIES; i++) if (m_v[i] && m_vpn[i] == v) idx = i;
    ea = ent_addr(m_base, v);
    e  = (idx >= 0) ? m_pte[idx] : mem_word(ea);
    exp_flt = !(e[22] && perm_ok(e[21:20], op));
    exp_pa  = exp_flt ? 32'h0 : {e[19:0], va[11:0]};
    r0 = rsp_cnt;
    run_req(va, op, with_base, nb, flt, pa, first_rdy, rc);
    check(flt == exp_flt, tag, "R5 fault", 32'(flt), 32'(exp_flt));
    check(pa == exp_pa, tag, "R4 R7 paddr", pa, exp_pa);
    if (with_base) check(first_rdy == 1'b0, tag, "R11 ready during base write", 32'(first_rdy), 32'h0);
    if (idx >= 0) begin
      check(first_rdy == 1'b1, tag, "R2 same-cycle hit", 32'(first_rdy), 32'h1);
      check(rsp_cnt == r0, tag, "R2 reads on hit", 32'(rsp_cnt - r0), 32'h0);
    end else begin
      check(first_rdy == 1'b0, tag, "R3 stall on miss", 32'(first_rdy), 32'h0);
      check(rsp_cnt - r0 == 1, tag, "R3 reads on miss", 32'(rsp_cnt - r0), 32'h1);
      check(last_addr == ea, tag, "R3 entry address", last_addr, ea);
      check(rc == rsp_cyc + 1, tag, "R3 result cycle", 32'(rc), 32'(rsp_cyc + 1));
      if (!exp_flt) model_install(v, e);
    end
  endtask

  task automatic discard_case(logic [31:0] b1, logic [31:0] b2, logic [31:0] va);
    logic [19:0] v;
    logic [22:0] e;
    logic        exp_flt;
    logic [31:0] exp_pa;
    int          r0;
    v = va[31:12];
    write_base(b1);
    @(negedge clk);
    hold_rsp  = 1'b1;
    req_valid = 1'b1;
    req_vaddr = va;
    req_op    = 2'd0;
    #1;
    while (!pte_rd) begin
      @(negedge clk);
      #1;
    end
    check(pte_rd_addr == ent_addr(b1, v), "R9", "first read address", pte_rd_addr, ent_addr(b1, v));
    @(negedge clk);
    tbl_base_we    = 1'b1;
    tbl_base_wdata = b2;
    @(negedge clk);
    tbl_base_we = 1'b0;
    hold_rsp    = 1'b0;
    model_flush(b2);
    r0 = rsp_cnt;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    e       = mem_word(ent_addr(b2, v));
    exp_flt = !(e[22] && e[21:20] != 2'd2);
    exp_pa  = exp_flt ? 32'h0 : {e[19:0], va[11:0]};
    check(rsp_cnt - r0 == 2, "R9", "reads old+new", 32'(rsp_cnt - r0), 32'h2);
    check(last_addr == ent_addr(b2, v), "R9", "refetch address", last_addr, ent_addr(b2, v));
    check(xl_fault == exp_flt, "R9", "fault from new table", 32'(xl_fault), 32'(exp_flt));
    check(xl_paddr == exp_pa, "R9", "paddr from new table", xl_paddr, exp_pa);
    if (!exp_flt) model_install(v, e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [19:0] fv, good [9];
    logic [22:0] e;
    int          ng;
    rst_n          = 1'b0;
    req_valid      = 1'b0;
    req_vaddr      = '0;
    req_op         = '0;
    tbl_base_we    = 1'b0;
    tbl_base_wdata = '0;
    for (int i = 0; i < ENTRIES; i++) m_v[i] = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(req_ready == 1'b0, "R1", "ready after reset", 32'(req_ready), 32'h0);
    check(pte_rd == 1'b0, "R1", "no read after reset", 32'(pte_rd), 32'h0);
    check_xact(32'h0001_2345, 2'd0, 1'b0, 32'h0, "R1");
    check_xact(32'h0001_2ABC, 2'd0, 1'b0, 32'h0, "R2");

    // faulting entry is fetched on every request
    write_base(32'h0010_0000);
    fv = '0;
    for (int v = 100; v < 600; v++) begin
      e = mem_word(ent_addr(m_base, 20'(v)));
      if (!e[22]) begin
        fv = 20'(v);
        break;
      end
    end
    check_xact({fv, 12'h123}, 2'd0, 1'b0, 32'h0, "R6");
    check_xact({fv, 12'h456}, 2'd0, 1'b0, 32'h0, "R6");

    // free slots first, then round robin
    write_base(32'h0004_0000);
    ng = 0;
    for (int v = 1; v < 2000 && ng < 9; v++) begin
      e = mem_word(ent_addr(m_base, 20'(v)));
      if (e[22] && e[21:20] != 2'd2) begin
        good[ng] = 20'(v);
        ng++;
      end
    end
    for (int i = 0; i < 9; i++) check_xact({good[i], 12'($urandom)}, 2'd0, 1'b0, 32'h0, "R10");
    for (int i = 0; i < 8; i++) check_xact({good[i], 12'($urandom)}, 2'd0, 1'b0, 32'h0, "R10");

    // base write flushes
    write_base(32'h0008_0000);
    check_xact({good[1], 12'h0F0}, 2'd0, 1'b0, 32'h0, "R8");
    check_xact({good[1], 12'h0F4}, 2'd0, 1'b0, 32'h0, "R8");

    // base write in the same cycle as a request to a cached page
    check_xact({good[1], 12'h010}, 2'd0, 1'b1, 32'h000C_0000, "R11");

    // base write while a read is outstanding
    discard_case(32'h0020_0000, 32'h0030_0000, {good[2], 12'h77C});

    // random mix
    for (int t = 0; t < 400; t++) begin
      logic [19:0] vp;
      logic [1:0]  op;
      bit          wb;
      vp = 20'(($urandom_range(0, 11) * 32'h1357) + 32'h10);
      op = 2'($urandom_range(0, 3));
      wb = ($urandom_range(0, 24) == 0);
      if (t % 50 == 49) write_base($urandom & 32'hFFFF_FFFC);
      check_xact({vp, 12'($urandom)}, op, wb, $urandom & 32'hFFFF_FFFC, "rand");
    end

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule